// File: doc/BRIEF.md
# Banked Memory Address Translator

This block widens the 16-bit logical address of an 8-bit processor into a 19-bit physical address, so that the processor can reach 512K bytes. Three software-written registers control the mapping. The boundary register splits the logical space into three areas, each 4K pages wide:

- a lower common area that passes through unchanged;
- a bank area, relocated by the bank base;
- an upper common area, relocated by the upper base.

Translation works on the top nibble of the logical address, which is the 4K page number. The block finds which area the page falls in. For the two relocated areas it adds a 7-bit base to the page number, and the sum becomes physical bits 18:12. The low twelve bits pass straight through.

The registers are reached through a small port. That port has a 2-bit select, a write strobe with write data, and a combinational read-back. The top physical address line leaves the chip on a pin that is shared with a timer pulse, and a control input picks which of the two drives the pin. Translation is combinational, so the physical address follows the logical address within the same cycle. A register write changes the mapping from the next clock edge.

Top module: `page_mapper`

## Requirements
- R1: After reset, all three registers read zero and every logical address maps to the physical address with the same low 16 bits and bits 18:16 zero.
- R2: Physical bits 11:0 always equal logical bits 11:0.
- R3: With page = logical[15:12], if page >= boundary[7:4] (the upper-area start page), then physical[18:12] = upper base + page. This test takes priority over the bank test when the boundaries overlap.
- R4: If page >= boundary[3:0] (the bank start page) and page < boundary[7:4], then physical[18:12] = bank base + page.
- R5: If page is below both boundary nibbles, then physical[18:12] = {3'b000, page}, so the physical address equals the logical address.
- R6: With boundary F2h, bank base 20h and upper base 70h, the following mappings hold: 402Ch→2402Ch, F21Ah→7F21Ah, 0000h→00000h, 1FFFh→01FFFh, 2000h→22000h, EFFFh→2EFFFh and F000h→7F000h.
- R7: The 7-bit page sum wraps modulo 128. For example, upper base 7Fh with logical F123h gives physical 0E123h.
- R8: Register select codes are 0 = boundary, 1 = bank base and 2 = upper base. Each register reads back at its own code. The base registers keep only 7 bits, so bit 7 reads 0 (writing FFh reads back 7Fh). Select 3 reads 00h, and a write to select 3 changes no register and no mapping.
- R9: A register write made in the same cycle as a translation does not affect that cycle's result. The new value governs the mapping from the cycle after the clock edge.
- R10: When the pin-select input is 0, the shared pin carries physical bit 18. When it is 1, the pin carries the timer pulse input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| log_addr | input | 16 | Logical address from the processor |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register select (0 boundary, 1 bank base, 2 upper base) |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the selected register |
| tout_sel | input | 1 | Pin source select: 0 address bit 18, 1 timer pulse |
| tout_in | input | 1 | Timer pulse input |
| phys_addr | output | 19 | Translated physical address |
| hi_pin | output | 1 | Shared pin: physical bit 18 or timer pulse |

## Verification
A register write and a translation can fall in the same cycle. This happens when software reloads the bank base while the logical address bus still presents an address in that bank.

The bench provokes this by holding a bank address and raising the write strobe in that cycle. It expects the old mapping and the old read-back value before the clock edge, and the new mapping in the following cycle. A second overlap tests area priority: a boundary value whose upper start lies below the bank start must send pages at or above the upper start to the upper area.

// File: rtl/page_mapper_pkg.sv
package page_mapper_pkg;

    localparam int LA_W   = 16;
    localparam int PA_W   = 19;
    localparam int OFF_W  = 12;
    localparam int PAGE_W = LA_W - OFF_W;
    localparam int BASE_W = PA_W - OFF_W;
    localparam int REG_W  = 8;
    localparam int SEL_W  = 2;

    typedef enum logic [SEL_W-1:0] {
        SEL_BOUND = 2'd0,
        SEL_BANK  = 2'd1,
        SEL_UPPER = 2'd2,
        SEL_SPARE = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        AREA_LOW   = 2'd0,
        AREA_BANK  = 2'd1,
        AREA_UPPER = 2'd2
    } area_e;

    typedef struct packed {
        logic [REG_W-1:0]  bound;
        logic [BASE_W-1:0] bank;
        logic [BASE_W-1:0] upper;
    } map_regs_t;

endpackage

// File: rtl/pm_regs.sv
module pm_regs
    import page_mapper_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SEL_W-1:0] sel,
    input  logic [REG_W-1:0] wdata,
    output map_regs_t        regs,
    output logic [REG_W-1:0] rdata
);

    map_regs_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (we) begin
            case (reg_sel_e'(sel))
                SEL_BOUND: state_d.bound = wdata;
                SEL_BANK:  state_d.bank  = wdata[BASE_W-1:0];
                SEL_UPPER: state_d.upper = wdata[BASE_W-1:0];
                default:   state_d = state_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        case (reg_sel_e'(sel))
            SEL_BOUND: rdata = state_q.bound;
            SEL_BANK:  rdata = REG_W'(state_q.bank);
            SEL_UPPER: rdata = REG_W'(state_q.upper);
            default:   rdata = '0;
        endcase
    end

    assign regs = state_q;

    AST_BOUND_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_BOUND) |=> (state_q.bound == $past(wdata))); // R9

    AST_SPARE_SEL_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_SPARE) |=> $stable(state_q)); // R8

endmodule

// File: rtl/pm_xlate.sv
module pm_xlate
    import page_mapper_pkg::*;
(
    input  logic [LA_W-1:0] log_addr,
    input  map_regs_t       regs,
    output area_e           area,
    output logic [PA_W-1:0] phys_addr
);

    logic [PAGE_W-1:0] page;
    logic [PAGE_W-1:0] upper_start;
    logic [PAGE_W-1:0] bank_start;
    logic [BASE_W-1:0] base_sel;
    logic [BASE_W-1:0] phys_page;

    assign page        = log_addr[LA_W-1:OFF_W];
    assign upper_start = regs.bound[REG_W-1:REG_W-PAGE_W];
    assign bank_start  = regs.bound[PAGE_W-1:0];

    always_comb begin
        if (page >= upper_start) begin
            area = AREA_UPPER;
        end else if (page >= bank_start) begin
            area = AREA_BANK;
        end else begin
            area = AREA_LOW;
        end
    end

    always_comb begin
        case (area)
            AREA_UPPER: base_sel = regs.upper;
            AREA_BANK:  base_sel = regs.bank;
            default:    base_sel = '0;
        endcase
        phys_page = base_sel + BASE_W'(page);
    end

    assign phys_addr = {phys_page, log_addr[OFF_W-1:0]};

endmodule

// File: rtl/page_mapper.sv
module page_mapper
    import page_mapper_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LA_W-1:0]  log_addr,
    input  logic             cfg_we,
    input  logic [SEL_W-1:0] cfg_sel,
    input  logic [REG_W-1:0] cfg_wdata,
    output logic [REG_W-1:0] cfg_rdata,
    input  logic             tout_sel,
    input  logic             tout_in,
    output logic [PA_W-1:0]  phys_addr,
    output logic             hi_pin
);

    map_regs_t regs;
    area_e     area;

    pm_regs u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .sel   (cfg_sel),
        .wdata (cfg_wdata),
        .regs  (regs),
        .rdata (cfg_rdata)
    );

    pm_xlate u_xlate (
        .log_addr  (log_addr),
        .regs      (regs),
        .area      (area),
        .phys_addr (phys_addr)
    );

    assign hi_pin = tout_sel ? tout_in : phys_addr[PA_W-1];

    AST_OFFSET_THRU: assert property (@(posedge clk) disable iff (!rst_n)
        phys_addr[OFF_W-1:0] == log_addr[OFF_W-1:0]); // R2

    AST_LOW_IDENTITY: assert property (@(posedge clk) disable iff (!rst_n)
        ((log_addr[LA_W-1:OFF_W] < regs.bound[PAGE_W-1:0]) &&
         (log_addr[LA_W-1:OFF_W] < regs.bound[REG_W-1:REG_W-PAGE_W]))
        |-> (phys_addr == PA_W'(log_addr))); // R5

    AST_PIN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        !tout_sel |-> (hi_pin == phys_addr[PA_W-1])); // R10

    AST_PIN_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
        tout_sel |-> (hi_pin == tout_in)); // R10

endmodule

// File: tb/page_mapper_bench.sv
module page_mapper_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] log_addr = '0;
    logic        cfg_we = 1'b0;
    logic [1:0]  cfg_sel = '0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic        tout_sel = 1'b0;
    logic        tout_in = 1'b0;
    logic [18:0] phys_addr;
    logic        hi_pin;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [18:0] phys;
        logic        pin;
        logic [7:0]  rd;
        string       tag;
    } item_t;

    item_t sb_q[$];

    always #5 clk = ~clk;

    page_mapper u_page_mapper (
        .clk       (clk),
        .rst_n     (rst_n),
        .log_addr  (log_addr),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .tout_sel  (tout_sel),
        .tout_in   (tout_in),
        .phys_addr (phys_addr),
        .hi_pin    (hi_pin)
    );

    task automatic push(input logic [18:0] ep, input logic [7:0] er, input string tag);
        item_t it;
        it.phys = ep;
        it.pin  = tout_sel ? tout_in : ep[18];
        it.rd   = er;
        it.tag  = tag;
        sb_q.push_back(it);
    endtask

    task automatic probe(input logic [15:0] la, input logic [1:0] s,
                         input logic [18:0] ep, input logic [7:0] er, input string tag);
        @(negedge clk);
        cfg_we   = 1'b0;
        log_addr = la;
        cfg_sel  = s;
        push(ep, er, tag);
    endtask

    task automatic probe_wr(input logic [15:0] la, input logic [1:0] s, input logic [7:0] d,
                            input logic [18:0] ep, input logic [7:0] er, input string tag);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_wdata = d;
        log_addr  = la;
        cfg_sel   = s;
        push(ep, er, tag);
    endtask

    task automatic wr(input logic [1:0] s, input logic [7:0] d);
        @(negedge clk);
        cfg_we    = 1'b1;
        cfg_sel   = s;
        cfg_wdata = d;
    endtask

    task automatic set_tout(input logic s, input logic v);
        @(negedge clk);
        cfg_we   = 1'b0;
        tout_sel = s;
        tout_in  = v;
    endtask

    initial begin
        forever begin
            @(negedge clk);
            #4;
            while (sb_q.size() > 0) begin
                item_t it;
                it = sb_q.pop_front();
                checks++;
                if (phys_addr !== it.phys || hi_pin !== it.pin || cfg_rdata !== it.rd) begin
                    errors++;
                    $display("FAIL %s: phys=%05h pin=%0b rd=%02h expected phys=%05h pin=%0b rd=%02h",
                             it.tag, phys_addr, hi_pin, cfg_rdata, it.phys, it.pin, it.rd);
                end
            end
        end
    end

    initial begin
        #1000000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state, identity mapping
        probe(16'hF21A, 2'd0, 19'h0F21A, 8'h00, "R1 bound reset");
        probe(16'h402C, 2'd1, 19'h0402C, 8'h00, "R1 bank reset");
        probe(16'h0000, 2'd2, 19'h00000, 8'h00, "R1 upper reset");

        wr(2'd0, 8'hF2);
        wr(2'd1, 8'h20);
        wr(2'd2, 8'h70);
        // R8: read back
        probe(16'h402C, 2'd0, 19'h2402C, 8'hF2, "R8 R6 R4 bound readback");
        probe(16'hF21A, 2'd1, 19'h7F21A, 8'h20, "R8 R6 R3 bank readback");
        probe(16'h0000, 2'd2, 19'h00000, 8'h70, "R8 R6 R5 upper readback");
        // R6 / R5 / R4 / R3 boundaries
        probe(16'h1FFF, 2'd0, 19'h01FFF, 8'hF2, "R5 R6 last low page");
        probe(16'h2000, 2'd0, 19'h22000, 8'hF2, "R4 R6 first bank page");
        probe(16'hEFFF, 2'd0, 19'h2EFFF, 8'hF2, "R4 R6 last bank page");
        probe(16'hF000, 2'd0, 19'h7F000, 8'hF2, "R3 R6 first upper page");
        probe(16'h5ABC, 2'd0, 19'h25ABC, 8'hF2, "R2 offset pass");

        // R7: wrap, R8: bit 7 of base dropped
        wr(2'd2, 8'hFF);
        probe(16'hF123, 2'd2, 19'h0E123, 8'h7F, "R7 R8 wrap and 7-bit base");

        // R8: spare select
        wr(2'd3, 8'hAA);
        probe(16'h402C, 2'd3, 19'h2402C, 8'h00, "R8 spare select reads zero");
        probe(16'hF123, 2'd0, 19'h0E123, 8'hF2, "R8 spare write inert");
        probe(16'h3000, 2'd1, 19'h23000, 8'h20, "R8 spare write inert bank");

        wr(2'd2, 8'h70);
        // R9: write and translate in the same cycle
        probe_wr(16'h402C, 2'd1, 8'h40, 19'h2402C, 8'h20, "R9 old mapping in write cycle");
        probe(16'h402C, 2'd1, 19'h4402C, 8'h40, "R9 new mapping next cycle");

        // R10: pin mux
        probe(16'hF21A, 2'd0, 19'h7F21A, 8'hF2, "R10 pin from address");
        probe(16'h0123, 2'd0, 19'h00123, 8'hF2, "R10 pin from address low");
        set_tout(1'b1, 1'b0);
        probe(16'hF21A, 2'd0, 19'h7F21A, 8'hF2, "R10 pin from timer 0");
        set_tout(1'b1, 1'b1);
        probe(16'h0000, 2'd0, 19'h00000, 8'hF2, "R10 pin from timer 1");
        set_tout(1'b0, 1'b1);
        probe(16'h0000, 2'd0, 19'h00000, 8'hF2, "R10 pin back to address");

        // R3: upper start below bank start takes priority
        wr(2'd0, 8'h35);
        probe(16'h4000, 2'd0, 19'h74000, 8'h35, "R3 upper priority over bank");
        probe(16'h3000, 2'd0, 19'h73000, 8'h35, "R3 upper start page");
        probe(16'h2ABC, 2'd0, 19'h02ABC, 8'h35, "R5 below both starts");

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule